// File: doc/BRIEF.md
# Display-Fetch Bus Glue for a Minimal Home Computer

This block is the glue between an 8-bit CPU bus, a small program ROM, a 1 KB RAM and a monochrome video path. The CPU presents one bus cycle per clock: a memory read, an opcode fetch, a memory write, an I/O read, an I/O write or an interrupt acknowledge. Each cycle is tagged by `cyc_kind`. The block decodes the cycle, returns read data one clock later, and updates the sync and interrupt state. The system clock is 3.25 MHz.

Video works by theft. When the CPU fetches an opcode from the upper half of memory, the RAM byte goes to the video path. The CPU sees a zero byte instead, which it executes as a no-operation. This only happens when the byte is a displayable character (bit 6 clear) and the CPU is not halted. Frame sync comes from port accesses and line sync from interrupt acknowledges. Line sync ends on the next opcode fetch. The interrupt request is refreshed on every opcode fetch from bit 6 of the refresh counter.

A one-cycle `video_stb` with `video_byte` stands in for character lookup and pixel shifting.

Top module: `zxv_bus_glue`

## Requirements
- R1: While reset is applied, `sync_out`, `sync_edge`, `dbus_oe` and `video_stb` are 0 and `int_n` is 1.
- R2: An I/O write whose address bits 2:0 equal 7 clears frame sync. Other I/O writes leave it unchanged. An I/O write never sets `dbus_oe`.
- R3: An I/O read returns 0xFF with `dbus_oe` high on the next cycle. When address bits 2:0 equal 6, it also sets frame sync.
- R4: An interrupt acknowledge (`cyc_kind`=5) returns 0xFF and sets line sync.
- R5: An opcode fetch (`cyc_kind`=1) clears line sync.
- R6: On an opcode fetch, `int_n` takes the value of `rfsh_b6` on the next cycle, so it goes low when bit 6 is 0. In all other cycles `int_n` holds its value.
- R7: A read or fetch with address bits 15:14 = 00 selects ROM. `rom_addr` is the address masked to ROM_AW bits, and `rom_data` is returned on the next cycle.
- R8: Any address with bit 14 set selects the 1 KB RAM through address bits 9:0, so the RAM is mirrored. Writes with bit 14 clear are dropped.
- R9: A display fetch is an opcode fetch with bit 15 set, a RAM byte with bit 6 clear and `cpu_halt` low. On the next cycle it raises `video_stb` for one cycle, puts the byte on `video_byte`, and returns 0x00.
- R10: Any other RAM read or fetch returns the stored byte unchanged, with `video_stb` low.
- R11: `sync_out` is the OR of line and frame sync. `sync_edge` pulses for one cycle exactly when `sync_out` changes level.
- R12: A read with address bits 15:14 = 10 selects nothing and leaves `dbus_oe` low.

Encodings for `cyc_kind`: 0 memory read, 1 opcode fetch, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge. Codes 6 and 7 are ignored.

Response states: IDLE (no drive), FF (I/O read or acknowledge), ROM, RAM (pass-through) and DISP (candidate display fetch).

Sync states are LEVEL, LINE, FRAME and BOTH. The transitions are:
- line start: LEVEL→LINE or FRAME→BOTH, taken on an acknowledge.
- line end: LINE→LEVEL or BOTH→FRAME, taken on a fetch.
- frame start: LEVEL→FRAME or LINE→BOTH, taken on a port-6 read.
- frame end: FRAME→LEVEL or BOTH→LINE, taken on a port-7 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| cyc_kind | input | 3 | Bus cycle type (encoding in requirements) |
| cyc_addr | input | 16 | Bus address |
| cyc_wdata | input | 8 | CPU write data |
| rfsh_b6 | input | 1 | Refresh counter bit 6 during the fetch |
| cpu_halt | input | 1 | CPU is in the halted state |
| rom_data | input | 8 | ROM byte at `rom_addr` |
| rom_addr | output | 12 | Masked ROM address |
| dbus_out | output | 8 | Data returned to the CPU |
| dbus_oe | output | 1 | `dbus_out` is valid and driven |
| video_byte | output | 8 | Captured display byte |
| video_stb | output | 1 | One-cycle capture strobe |
| sync_out | output | 1 | Composite sync level |
| sync_edge | output | 1 | Composite sync changed this cycle |
| int_n | output | 1 | Maskable interrupt request, active low |

## Verification
Every result appears exactly one cycle after the clock edge that samples the bus cycle. This covers read data, `dbus_oe`, the video strobe, the new sync state with its edge pulse, and `int_n`. `rom_addr` is the only exception; it is combinational.

The driver presents a cycle just after a falling edge and pushes its expected response. The monitor pops that response a quarter period after the next rising edge and compares every output. Idle cycles push expectations too, so a strobe or edge pulse that lasts too long is caught on the following cycle.

// File: rtl/zxv_pkg.sv
package zxv_pkg;

    typedef enum logic [2:0] {
        BUS_MEMRD  = 3'd0,
        BUS_FETCH  = 3'd1,
        BUS_MEMWR  = 3'd2,
        BUS_IORD   = 3'd3,
        BUS_IOWR   = 3'd4,
        BUS_INTACK = 3'd5
    } bus_kind_e;

    // bit 1 = frame sync, bit 0 = line sync
    typedef enum logic [1:0] {
        SY_LEVEL = 2'b00,
        SY_LINE  = 2'b01,
        SY_FRAME = 2'b10,
        SY_BOTH  = 2'b11
    } sync_st_e;

    typedef enum logic [2:0] {
        RSP_IDLE,
        RSP_FF,
        RSP_ROM,
        RSP_RAM,
        RSP_DISP
    } rsp_e;

    typedef struct packed {
        logic rom_sel;
        logic ram_sel;
        logic disp_hi;
    } mem_dec_t;

endpackage

// File: rtl/zxv_addr_dec.sv
module zxv_addr_dec
    import zxv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROM_AW = 12,
    parameter int RAM_AW = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output mem_dec_t          dec,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr
);
    localparam int TOP_BIT = ADDR_W - 1;
    localparam int SEL_BIT = ADDR_W - 2;

    always_comb begin
        dec.rom_sel = (addr[TOP_BIT:SEL_BIT] == 2'b00);
        dec.ram_sel = addr[SEL_BIT];
        dec.disp_hi = addr[TOP_BIT];
    end

    assign rom_addr = addr[ROM_AW-1:0];
    assign ram_addr = addr[RAM_AW-1:0];

    generate
        if (ROM_AW < SEL_BIT) begin : g_gap
            logic unused_gap_bits;
            assign unused_gap_bits = ^addr[SEL_BIT-1:ROM_AW];
        end
    endgenerate
endmodule

// File: rtl/zxv_ram.sv
module zxv_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/zxv_sync_fsm.sv
module zxv_sync_fsm
    import zxv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_set,
    input  logic line_clr,
    input  logic frame_set,
    input  logic frame_clr,
    output logic sync_out,
    output logic sync_edge
);
    sync_st_e st_q, st_d;
    logic     line_nx, frame_nx;
    logic     comp_now, comp_nx;

    // next state: line start / line end / frame start / frame end
    always_comb begin
        line_nx  = st_q[0];
        frame_nx = st_q[1];
        if (line_set)       line_nx  = 1'b1;
        else if (line_clr)  line_nx  = 1'b0;
        if (frame_set)      frame_nx = 1'b1;
        else if (frame_clr) frame_nx = 1'b0;
        st_d = sync_st_e'({frame_nx, line_nx});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= SY_LEVEL;
            sync_edge <= 1'b0;
        end else begin
            st_q      <= st_d;
            sync_edge <= comp_now ^ comp_nx;
        end
    end

    always_comb begin
        comp_nx = (st_d != SY_LEVEL);
        unique case (st_q)
            SY_LEVEL: comp_now = 1'b0;
            SY_LINE:  comp_now = 1'b1;
            SY_FRAME: comp_now = 1'b1;
            SY_BOTH:  comp_now = 1'b1;
            default:  comp_now = 1'b0;
        endcase
        sync_out = comp_now;
    end
endmodule

// File: rtl/zxv_bus_glue.sv
module zxv_bus_glue
    import zxv_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int ROM_AW      = 12,
    parameter int RAM_AW      = 10,
    parameter int PORT_BITS   = 3,
    parameter int VS_SET_PORT = 6,
    parameter int VS_CLR_PORT = 7,
    parameter int VID_BIT     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic [2:0]        cyc_kind,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_wdata,
    input  logic              rfsh_b6,
    input  logic              cpu_halt,
    input  logic [DATA_W-1:0] rom_data,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [DATA_W-1:0] dbus_out,
    output logic              dbus_oe,
    output logic [DATA_W-1:0] video_byte,
    output logic              video_stb,
    output logic              sync_out,
    output logic              sync_edge,
    output logic              int_n
);
    localparam logic [DATA_W-1:0] BUS_FLOAT = '1;
    localparam logic [DATA_W-1:0] NOP_BYTE  = '0;
    localparam logic [PORT_BITS-1:0] P_SET = PORT_BITS'(VS_SET_PORT);
    localparam logic [PORT_BITS-1:0] P_CLR = PORT_BITS'(VS_CLR_PORT);

    bus_kind_e kind;
    mem_dec_t  dec;
    logic [RAM_AW-1:0] ram_addr;
    logic [DATA_W-1:0] ram_q, rom_q;
    logic is_fetch, is_wr, is_iord, is_iowr, is_ack;
    rsp_e rsp_q, rsp_d;

    assign kind     = bus_kind_e'(cyc_kind);
    assign is_fetch = cyc_valid && (kind == BUS_FETCH);
    assign is_wr    = cyc_valid && (kind == BUS_MEMWR);
    assign is_iord  = cyc_valid && (kind == BUS_IORD);
    assign is_iowr  = cyc_valid && (kind == BUS_IOWR);
    assign is_ack   = cyc_valid && (kind == BUS_INTACK);

    zxv_addr_dec #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_dec (
        .addr     (cyc_addr),
        .dec      (dec),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr)
    );

    zxv_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (is_wr && dec.ram_sel),
        .addr  (ram_addr),
        .wdata (cyc_wdata),
        .rdata (ram_q)
    );

    zxv_sync_fsm u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_set  (is_ack),
        .line_clr  (is_fetch),
        .frame_set (is_iord && (cyc_addr[PORT_BITS-1:0] == P_SET)),
        .frame_clr (is_iowr && (cyc_addr[PORT_BITS-1:0] == P_CLR)),
        .sync_out  (sync_out),
        .sync_edge (sync_edge)
    );

    // response chosen for the cycle presented now
    always_comb begin
        rsp_d = RSP_IDLE;
        if (cyc_valid) begin
            unique case (kind)
                BUS_MEMRD, BUS_FETCH: begin
                    if (dec.rom_sel)
                        rsp_d = RSP_ROM;
                    else if (dec.ram_sel)
                        rsp_d = (is_fetch && dec.disp_hi && !cpu_halt) ? RSP_DISP : RSP_RAM;
                    else
                        rsp_d = RSP_IDLE;
                end
                BUS_IORD, BUS_INTACK: rsp_d = RSP_FF;
                default:              rsp_d = RSP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= RSP_IDLE;
            rom_q <= '0;
            int_n <= 1'b1;
        end else begin
            rsp_q <= rsp_d;
            rom_q <= rom_data;
            if (is_fetch)
                int_n <= rfsh_b6;
        end
    end

    // outputs from the response state
    always_comb begin
        dbus_out   = NOP_BYTE;
        dbus_oe    = 1'b0;
        video_byte = '0;
        video_stb  = 1'b0;
        unique case (rsp_q)
            RSP_IDLE: dbus_oe = 1'b0;
            RSP_FF: begin
                dbus_oe  = 1'b1;
                dbus_out = BUS_FLOAT;
            end
            RSP_ROM: begin
                dbus_oe  = 1'b1;
                dbus_out = rom_q;
            end
            RSP_RAM: begin
                dbus_oe  = 1'b1;
                dbus_out = ram_q;
            end
            RSP_DISP: begin
                dbus_oe = 1'b1;
                if (!ram_q[VID_BIT]) begin
                    dbus_out   = NOP_BYTE;
                    video_stb  = 1'b1;
                    video_byte = ram_q;
                end else begin
                    dbus_out = ram_q;
                end
            end
            default: dbus_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/zxv_bus_glue_chk.sv
module zxv_bus_glue_chk
    import zxv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_valid,
    input logic [2:0]        cyc_kind,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic [DATA_W-1:0] dbus_out,
    input logic              dbus_oe,
    input logic [DATA_W-1:0] video_byte,
    input logic              video_stb,
    input logic              sync_out,
    input logic              sync_edge,
    input logic              int_n
);
    localparam int TOP_BIT = ADDR_W - 1;

    p_iowr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == BUS_IOWR) |=> !dbus_oe);

    p_iord_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == BUS_IORD) |=> (dbus_oe && dbus_out == '1));

    p_ack_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == BUS_INTACK) |=> (dbus_oe && dbus_out == '1 && sync_out));

    p_int_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_valid && cyc_kind == BUS_FETCH) |=> $stable(int_n));

    p_vid_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        video_stb |-> (dbus_oe && dbus_out == '0 && !video_byte[6]));

    p_vid_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        video_stb |-> $past(cyc_valid && cyc_kind == BUS_FETCH && cyc_addr[TOP_BIT]));

    p_edge_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sync_edge |-> (sync_out != $past(sync_out)));

    p_change_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out != $past(sync_out)) |-> sync_edge);
endmodule

bind zxv_bus_glue zxv_bus_glue_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_valid  (cyc_valid),
    .cyc_kind   (cyc_kind),
    .cyc_addr   (cyc_addr),
    .dbus_out   (dbus_out),
    .dbus_oe    (dbus_oe),
    .video_byte (video_byte),
    .video_stb  (video_stb),
    .sync_out   (sync_out),
    .sync_edge  (sync_edge),
    .int_n      (int_n)
);

// File: tb/tb_zxv_bus_glue.sv
module tb_zxv_bus_glue;
    localparam int CLK_PERIOD = 20;

    localparam logic [2:0] K_RD = 3'd0, K_FE = 3'd1, K_WR = 3'd2,
                           K_IR = 3'd3, K_IW = 3'd4, K_AK = 3'd5;

    typedef struct {
        logic       oe;
        logic [7:0] d;
        logic       stb;
        logic [7:0] vb;
        logic       sy;
        logic       ed;
        logic       in;
        string      tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cyc_valid = 1'b0, rfsh_b6 = 1'b1, cpu_halt = 1'b0;
    logic [2:0]  cyc_kind = '0;
    logic [15:0] cyc_addr = '0;
    logic [7:0]  cyc_wdata = '0, rom_data, dbus_out, video_byte;
    logic [11:0] rom_addr;
    logic dbus_oe, video_stb, sync_out, sync_edge, int_n;

    int checks = 0, errors = 0;
    exp_t exp_q[$];
    logic [7:0] m_ram [1024];
    logic m_hs = 1'b0, m_vs = 1'b0, m_in = 1'b1;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rom_fn(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]};
    endfunction
    assign rom_data = rom_fn(rom_addr);

    zxv_bus_glue dut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
        .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .rfsh_b6(rfsh_b6),
        .cpu_halt(cpu_halt), .rom_data(rom_data), .rom_addr(rom_addr),
        .dbus_out(dbus_out), .dbus_oe(dbus_oe), .video_byte(video_byte),
        .video_stb(video_stb), .sync_out(sync_out), .sync_edge(sync_edge),
        .int_n(int_n)
    );

    // driver: present one cycle and push its expected response
    task automatic op(input logic v, input logic [2:0] k, input logic [15:0] a,
                      input logic [7:0] wd, input logic rf, input logic hl,
                      input string tag);
        exp_t e;
        logic prev;
        logic [7:0] b;
        @(negedge clk);
        cyc_valid = v; cyc_kind = k; cyc_addr = a; cyc_wdata = wd;
        rfsh_b6 = rf; cpu_halt = hl;
        e.oe = 0; e.d = 8'h00; e.stb = 0; e.vb = 8'h00; e.tag = tag;
        prev = m_hs | m_vs;
        if (v) begin
            case (k)
                K_RD, K_FE: begin
                    if (a[15:14] == 2'b00) begin
                        e.oe = 1; e.d = rom_fn(a[11:0]);
                    end else if (a[14]) begin
                        b = m_ram[a[9:0]];
                        e.oe = 1;
                        if (k == K_FE && a[15] && !b[6] && !hl) begin
                            e.stb = 1; e.vb = b; e.d = 8'h00;
                        end else begin
                            e.d = b;
                        end
                    end
                    if (k == K_FE) begin m_hs = 0; m_in = rf; end
                end
                K_WR: if (a[14]) m_ram[a[9:0]] = wd;
                K_IR: begin e.oe = 1; e.d = 8'hFF; if (a[2:0] == 3'd6) m_vs = 1; end
                K_IW: if (a[2:0] == 3'd7) m_vs = 0;
                K_AK: begin e.oe = 1; e.d = 8'hFF; m_hs = 1; end
                default: ;
            endcase
        end
        e.sy = m_hs | m_vs;
        e.ed = e.sy ^ prev;
        e.in = m_in;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        op(1'b0, K_RD, 16'h0000, 8'h00, rfsh_b6, 1'b0, tag);
    endtask

    // monitor: compare one cycle after each presented bus cycle
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (dbus_oe !== e.oe || (e.oe && dbus_out !== e.d) ||
                    video_stb !== e.stb || (e.stb && video_byte !== e.vb) ||
                    sync_out !== e.sy || sync_edge !== e.ed || int_n !== e.in) begin
                    errors++;
                    $display("FAIL %s actual oe=%b d=%h stb=%b vb=%h sy=%b ed=%b in=%b expected oe=%b d=%h stb=%b vb=%h sy=%b ed=%b in=%b",
                             e.tag, dbus_oe, dbus_out, video_stb, video_byte, sync_out,
                             sync_edge, int_n, e.oe, e.d, e.stb, e.vb, e.sy, e.ed, e.in);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (sync_out !== 0 || sync_edge !== 0 || dbus_oe !== 0 || video_stb !== 0 || int_n !== 1) begin
            errors++;
            $display("FAIL R1 reset actual sy=%b ed=%b oe=%b stb=%b in=%b expected 0 0 0 0 1",
                     sync_out, sync_edge, dbus_oe, video_stb, int_n);
        end
        rst_n = 1'b1;
        idle("R1 idle after reset");
        op(1, K_WR, 16'h4005, 8'h3A, 1, 0, "R8 write ram");
        op(1, K_WR, 16'h4006, 8'h47, 1, 0, "R8 write ram");
        op(1, K_WR, 16'h7C07, 8'h21, 1, 0, "R8 write mirror");
        op(1, K_RD, 16'h4407, 8'h00, 1, 0, "R8 read mirror");
        op(1, K_WR, 16'h0005, 8'hEE, 1, 0, "R8 rom-area write dropped");
        op(1, K_WR, 16'h8005, 8'hEE, 1, 0, "R8 gap write dropped");
        op(1, K_RD, 16'h4005, 8'h00, 1, 0, "R8 readback unchanged");
        op(1, K_RD, 16'h0123, 8'h00, 1, 0, "R7 rom read");
        op(1, K_RD, 16'h3ABC, 8'h00, 1, 0, "R7 rom mirror");
        op(1, K_FE, 16'h1234, 8'h00, 1, 0, "R7 rom fetch");
        op(1, K_RD, 16'h8005, 8'h00, 1, 0, "R12 unmapped read");
        op(1, K_IR, 16'h00FE, 8'h00, 1, 0, "R3 port6 read frame sync");
        op(1, K_AK, 16'h0000, 8'h00, 1, 0, "R4 ack no edge R11");
        op(1, K_IW, 16'h00FF, 8'h00, 1, 0, "R2 port7 write");
        op(1, K_FE, 16'hC005, 8'h00, 0, 0, "R9 display fetch R5 R6");
        idle("R9 strobe one cycle R6 hold");
        op(1, K_FE, 16'hC006, 8'h00, 1, 0, "R10 bit6 set passthrough R6");
        op(1, K_FE, 16'hC005, 8'h00, 1, 1, "R10 halted passthrough");
        op(1, K_FE, 16'h4005, 8'h00, 0, 0, "R10 low fetch passthrough");
        op(1, K_IR, 16'h0005, 8'h00, 0, 0, "R3 other port no sync");
        op(1, K_IW, 16'h00FE, 8'h00, 0, 0, "R2 other port write");
        op(1, K_AK, 16'h0000, 8'h00, 0, 0, "R4 ack line sync R11");
        op(1, K_RD, 16'h4006, 8'h00, 1, 0, "R6 int held on read");
        op(1, K_IR, 16'h0016, 8'h00, 1, 0, "R11 frame under line");
        op(1, K_IW, 16'h000F, 8'h00, 1, 0, "R2 frame off line on");
        op(1, K_FE, 16'h0010, 8'h00, 1, 0, "R5 fetch ends line R11");
        op(1, 3'd7, 16'hC005, 8'h00, 0, 0, "R6 unused kind ignored");
        idle("R11 quiet");
        idle("tail");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule